// File: doc/BRIEF.md
# Dual-Mode Call/Return Stack Controller

This block manages the subroutine stack of a small nibble-wide processor with a 14-bit program counter. It holds a 4-bit configuration register. The top bit of that register picks between a short-frame compatibility mode and a long-frame extended mode. The low bit picks which of two data-memory banks holds the stack. The other two bits are reserved, and writes that would set them are rejected.

On a push request the block stores the return address, nibble by nibble, through a 4-bit data-memory port. It pre-decrements an 8-bit stack pointer before each write. In extended mode it also stores an 8-bit status word. A pop request reads the frame back in reverse order and post-increments the pointer after each read. It then presents the restored address and, in extended mode, the restored status. The block also tells the decoder how many machine cycles a call costs in the current mode, and it flags the extended-only branch and call forms as illegal while compatibility mode is active.

Top module: `stack_frame_ctrl`

## Requirements
- R1: After reset the configuration reads 4'b1000 (compatibility mode, bank 0), the stack pointer is 8'h00, busy is low and the error flag is low.
- R2: A configuration write whose bits 2 and 1 are both 0 takes effect on the next clock edge. Bit 3 set to 1 means compatibility mode and 0 means extended mode. Bit 0 selects the stack bank.
- R3: A configuration write with bit 1 or bit 2 set is ignored and the old value is kept. The error flag is high for the one cycle after that write and low after any accepted write.
- R4: In compatibility mode a push performs 4 nibble writes while busy is high for 4 cycles, and leaves the stack pointer 4 lower. Each write goes to the pointer's value minus one. The nibbles are written in this order: PC[3:0], PC[7:4], PC[11:8], then {2'b00, PC[13:12]}. The low nibble therefore lands at the highest address.
- R5: In extended mode a push performs 6 nibble writes while busy is high for 6 cycles. The first four writes are the same as in R4. The next two are status[3:0] and then status[7:4].
- R6: A pop reads the frame starting at the current stack pointer and increments the pointer after each read. Busy is high for one cycle more than the frame length. The cycle after busy falls, the pop-done pulse is high, and the restored PC (and, in extended mode, the restored status) appear on the outputs. The pointer is back to its value from before the push.
- R7: The reported call latency is 3 cycles for a long call and 2 for a fast call in compatibility mode, and 4 and 3 in extended mode.
- R8: The illegal-operation output is high exactly when an extended-only operation is presented while compatibility mode is active.
- R9: A request that arrives while busy is high is not accepted until the running sequence ends, and a read and a write never occur in the same cycle. If push and pop are requested together while idle, push wins.
- R10: The memory address is {bank bit, 8-bit pointer}, so bank 1 frames occupy addresses 9'h100 to 9'h1FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 4 | Configuration write value |
| cfg_rdata | output | 4 | Current configuration |
| cfg_err | output | 1 | Rejected-write flag, one cycle |
| push_req | input | 1 | Call push request (level, held until accepted) |
| pop_req | input | 1 | Return pop request (level, held until accepted) |
| ret_pc | input | 14 | Return address to push |
| stat_in | input | 8 | Status word to push in extended mode |
| call_fast | input | 1 | 1 for a fast call, 0 for a long call |
| ext_only_op | input | 1 | Decoded op exists only in extended mode |
| busy | output | 1 | Sequence in progress |
| pop_done | output | 1 | Pop finished, restored values valid |
| pc_out | output | 14 | Restored return address |
| stat_out | output | 8 | Restored status word |
| sp_out | output | 8 | Stack pointer |
| call_cycles | output | 3 | Call latency in machine cycles |
| illegal_op | output | 1 | Extended-only op in compatibility mode |
| mem_we | output | 1 | Data memory write enable |
| mem_re | output | 1 | Data memory read enable |
| mem_addr | output | 9 | Data memory nibble address |
| mem_wdata | output | 4 | Data memory write nibble |
| mem_rdata | input | 4 | Data memory read nibble, valid the cycle after mem_re |

## Verification
The hardest situation to reach from the ports is a request that collides with a running sequence, because the pop request must arrive while a push is still in its middle cycles. The stimulus starts an extended-mode push and raises the pop request a few cycles later. It keeps that request held and watches every cycle that no read appears during the push. Only after the push ends does it confirm that the restored frame matches. A second collision drives push and pop in the same idle cycle to expose the priority.

// File: rtl/stack_frame_pkg.sv
package stack_frame_pkg;
   localparam int unsigned NIB_W = 4;
   localparam int unsigned CFG_W = 4;
   localparam int unsigned CFG_MODE_BIT = 3;
   localparam int unsigned CFG_BANK_BIT = 0;
   localparam logic [CFG_W-1:0] CFG_RESET = 4'b1000;
   localparam logic [CFG_W-1:0] CFG_RSVD_MASK = 4'b0110;

   typedef struct packed {
      logic compat;
      logic bank;
   } frame_cfg_t;
endpackage

// File: rtl/sfc_mode_reg.sv
module sfc_mode_reg
   import stack_frame_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CFG_W-1:0] wdata,
   output logic [CFG_W-1:0] cfg,
   output logic             err,
   output frame_cfg_t       fcfg
);
   logic [CFG_W-1:0] cfg_q;
   logic             err_q;
   logic             bad;

   assign bad = |(wdata & CFG_RSVD_MASK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= CFG_RESET;
         err_q <= 1'b0;
      end else begin
         err_q <= 1'b0;
         if (we) begin
            if (bad) err_q <= 1'b1;
            else     cfg_q <= wdata;
         end
      end
   end

   assign cfg         = cfg_q;
   assign err         = err_q;
   assign fcfg.compat = cfg_q[CFG_MODE_BIT];
   assign fcfg.bank   = cfg_q[CFG_BANK_BIT];

   assert_bad_write_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (we && bad) |=> $stable(cfg_q));
   assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q & CFG_RSVD_MASK) == '0);
endmodule

// File: rtl/sfc_call_timing.sv
module sfc_call_timing #(
   parameter int unsigned LONG_CYC = 3,
   parameter int unsigned FAST_CYC = 2,
   parameter int unsigned EXT_EXTRA = 1,
   parameter int unsigned CYC_W = 3
) (
   input  logic             compat,
   input  logic             fast,
   input  logic             ext_only,
   output logic [CYC_W-1:0] cycles,
   output logic             illegal
);
   generate
      if (LONG_CYC + EXT_EXTRA >= (1 << CYC_W)) begin : g_bad_w
         $error("call cycle width too small");
      end
   endgenerate

   localparam logic [CYC_W-1:0] C_LONG = CYC_W'(LONG_CYC);
   localparam logic [CYC_W-1:0] C_FAST = CYC_W'(FAST_CYC);
   localparam logic [CYC_W-1:0] C_EXT  = CYC_W'(EXT_EXTRA);

   always_comb begin
      cycles = fast ? C_FAST : C_LONG;
      if (!compat) cycles = cycles + C_EXT;
   end

   assign illegal = ext_only & compat;
endmodule

// File: rtl/sfc_sequencer.sv
module sfc_sequencer
   import stack_frame_pkg::*;
#(
   parameter int unsigned PC_W = 14,
   parameter int unsigned STAT_W = 8,
   parameter int unsigned SP_W = 8,
   parameter logic [SP_W-1:0] SP_RESET = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_push,
   input  logic              start_pop,
   input  frame_cfg_t        fcfg,
   input  logic [PC_W-1:0]   pc_in,
   input  logic [STAT_W-1:0] stat_in,
   output logic              busy,
   output logic              done,
   output logic [PC_W-1:0]   pc_out,
   output logic [STAT_W-1:0] stat_out,
   output logic [SP_W-1:0]   sp,
   output logic              mem_we,
   output logic              mem_re,
   output logic [SP_W:0]     mem_addr,
   output logic [NIB_W-1:0]  mem_wdata,
   input  logic [NIB_W-1:0]  mem_rdata
);
   localparam int unsigned PC_SLOTS  = (PC_W + NIB_W - 1) / NIB_W;
   localparam int unsigned ST_SLOTS  = STAT_W / NIB_W;
   localparam int unsigned ALL_SLOTS = PC_SLOTS + ST_SLOTS;
   localparam int unsigned PC_PAD    = PC_SLOTS * NIB_W - PC_W;
   localparam int unsigned STEP_W    = $clog2(ALL_SLOTS + 2);
   localparam logic [STEP_W-1:0] LEN_S = STEP_W'(PC_SLOTS);
   localparam logic [STEP_W-1:0] LEN_L = STEP_W'(ALL_SLOTS);

   generate
      if (STAT_W % NIB_W != 0) begin : g_bad_stat
         $error("status width must be whole nibbles");
      end
      if (PC_W < 1 || SP_W < 2) begin : g_bad_w
         $error("pc or pointer width out of range");
      end
   endgenerate

   logic                     busy_q, push_q, long_q, bank_q, done_q;
   logic [STEP_W-1:0]        step_q, len, cap_slot;
   logic [SP_W-1:0]          sp_q, sp_dec;
   logic [PC_W-1:0]          wr_pc_q, rd_pc_q;
   logic [STAT_W-1:0]        wr_st_q, rd_st_q;
   logic [PC_SLOTS*NIB_W-1:0] pc_pad;
   logic [ALL_SLOTS*NIB_W-1:0] wr_word;

   generate
      if (PC_PAD > 0) begin : g_pad
         assign pc_pad = {{PC_PAD{1'b0}}, wr_pc_q};
      end else begin : g_nopad
         assign pc_pad = wr_pc_q;
      end
   endgenerate

   assign wr_word  = {wr_st_q, pc_pad};
   assign len      = long_q ? LEN_L : LEN_S;
   assign cap_slot = len - step_q;
   assign sp_dec   = sp_q - 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         push_q  <= 1'b0;
         long_q  <= 1'b0;
         bank_q  <= 1'b0;
         done_q  <= 1'b0;
         step_q  <= '0;
         sp_q    <= SP_RESET;
         wr_pc_q <= '0;
         wr_st_q <= '0;
         rd_pc_q <= '0;
         rd_st_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (start_push || start_pop) begin
               busy_q <= 1'b1;
               push_q <= start_push;
               long_q <= ~fcfg.compat;
               bank_q <= fcfg.bank;
               step_q <= '0;
               if (start_push) begin
                  wr_pc_q <= pc_in;
                  wr_st_q <= stat_in;
               end
            end
         end else if (push_q) begin
            sp_q <= sp_dec;
            if (step_q == len - 1'b1) busy_q <= 1'b0;
            else                      step_q <= step_q + 1'b1;
         end else begin
            if (step_q < len) sp_q <= sp_q + 1'b1;
            if (step_q != '0) begin
               for (int b = 0; b < int'(PC_W); b++)
                  if (b / NIB_W == int'(cap_slot)) rd_pc_q[b] <= mem_rdata[b % NIB_W];
               for (int b = 0; b < int'(STAT_W); b++)
                  if (b / NIB_W + PC_SLOTS == int'(cap_slot)) rd_st_q[b] <= mem_rdata[b % NIB_W];
            end
            if (step_q == len) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end else begin
               step_q <= step_q + 1'b1;
            end
         end
      end
   end

   assign busy      = busy_q;
   assign done      = done_q;
   assign pc_out    = rd_pc_q;
   assign stat_out  = rd_st_q;
   assign sp        = sp_q;
   assign mem_we    = busy_q & push_q;
   assign mem_re    = busy_q & ~push_q & (step_q < len);
   assign mem_addr  = {bank_q, (mem_we ? sp_dec : sp_q)};
   assign mem_wdata = wr_word[{step_q, 2'b00} +: NIB_W];

   assert_push_predec_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> (sp_q == SP_W'($past(sp_q) - 1'b1)));
   assert_pop_postinc_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re |=> (sp_q == SP_W'($past(sp_q) + 1'b1)));
   assert_no_rw_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));
   assert_start_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> $past(start_push || start_pop));
   assert_addr_bank_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we || mem_re) |-> (mem_addr[SP_W] == bank_q));
endmodule

// File: rtl/stack_frame_ctrl.sv
module stack_frame_ctrl
   import stack_frame_pkg::*;
#(
   parameter int unsigned PC_W = 14,
   parameter int unsigned STAT_W = 8,
   parameter int unsigned SP_W = 8,
   parameter int unsigned CYC_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic [CFG_W-1:0]  cfg_rdata,
   output logic              cfg_err,
   input  logic              push_req,
   input  logic              pop_req,
   input  logic [PC_W-1:0]   ret_pc,
   input  logic [STAT_W-1:0] stat_in,
   input  logic              call_fast,
   input  logic              ext_only_op,
   output logic              busy,
   output logic              pop_done,
   output logic [PC_W-1:0]   pc_out,
   output logic [STAT_W-1:0] stat_out,
   output logic [SP_W-1:0]   sp_out,
   output logic [CYC_W-1:0]  call_cycles,
   output logic              illegal_op,
   output logic              mem_we,
   output logic              mem_re,
   output logic [SP_W:0]     mem_addr,
   output logic [NIB_W-1:0]  mem_wdata,
   input  logic [NIB_W-1:0]  mem_rdata
);
   frame_cfg_t fcfg;
   logic       go_push, go_pop;

   assign go_push = push_req & ~busy;
   assign go_pop  = pop_req & ~push_req & ~busy;

   sfc_mode_reg i_mode (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
      .cfg(cfg_rdata), .err(cfg_err), .fcfg(fcfg)
   );

   sfc_call_timing #(.CYC_W(CYC_W)) i_timing (
      .compat(fcfg.compat), .fast(call_fast), .ext_only(ext_only_op),
      .cycles(call_cycles), .illegal(illegal_op)
   );

   sfc_sequencer #(.PC_W(PC_W), .STAT_W(STAT_W), .SP_W(SP_W)) i_seq (
      .clk(clk), .rst_n(rst_n), .start_push(go_push), .start_pop(go_pop),
      .fcfg(fcfg), .pc_in(ret_pc), .stat_in(stat_in), .busy(busy),
      .done(pop_done), .pc_out(pc_out), .stat_out(stat_out), .sp(sp_out),
      .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );
endmodule

// File: tb/test_stack_frame_ctrl.sv
module test_stack_frame_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_wdata = '0;
   logic [3:0]  cfg_rdata;
   logic        cfg_err;
   logic        push_req = 1'b0, pop_req = 1'b0;
   logic [13:0] ret_pc = '0;
   logic [7:0]  stat_in = '0;
   logic        call_fast = 1'b0, ext_only_op = 1'b0;
   logic        busy, pop_done, illegal_op, mem_we, mem_re;
   logic [13:0] pc_out;
   logic [7:0]  stat_out, sp_out;
   logic [2:0]  call_cycles;
   logic [8:0]  mem_addr;
   logic [3:0]  mem_wdata;
   logic [3:0]  mem_rdata = '0;
   logic [3:0]  ram [512];
   int nchk = 0, nfail = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   stack_frame_ctrl i_stack_frame_ctrl (.*);

   always_ff @(posedge clk) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      if (mem_re) mem_rdata <= ram[mem_addr];
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [3:0] v);
      @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
      @(negedge clk); cfg_we = 1'b0;
   endtask

   task automatic do_push(input logic [13:0] pc, input logic [7:0] st, input int exp_len, input string req);
      int n = 0;
      @(negedge clk); push_req = 1'b1; ret_pc = pc; stat_in = st;
      @(negedge clk); push_req = 1'b0;
      while (busy) begin n++; @(negedge clk); end
      chk(n == exp_len, req, n, exp_len);
   endtask

   task automatic do_pop(input int exp_len, input string req);
      int n = 0;
      @(negedge clk); pop_req = 1'b1;
      @(negedge clk); pop_req = 1'b0;
      while (busy) begin n++; @(negedge clk); end
      chk(n == exp_len + 1, req, n, exp_len + 1);
      chk(pop_done == 1'b1, req, pop_done, 1);
   endtask

   task automatic t_reset;
      chk(cfg_rdata == 4'b1000, "R1 cfg", cfg_rdata, 4'b1000);
      chk(sp_out == 8'h00, "R1 sp", sp_out, 0);
      chk(busy == 1'b0, "R1 busy", busy, 0);
      chk(cfg_err == 1'b0, "R1 err", cfg_err, 0);
   endtask

   task automatic t_timing_compat;
      call_fast = 1'b0; ext_only_op = 1'b0; #1;
      chk(call_cycles == 3, "R7 long compat", call_cycles, 3);
      call_fast = 1'b1; #1;
      chk(call_cycles == 2, "R7 fast compat", call_cycles, 2);
      chk(illegal_op == 1'b0, "R8 legal op", illegal_op, 0);
      ext_only_op = 1'b1; #1;
      chk(illegal_op == 1'b1, "R8 ext op compat", illegal_op, 1);
      ext_only_op = 1'b0;
   endtask

   task automatic t_push_pop_compat;
      do_push(14'h2A5C, 8'hEE, 4, "R4 busy length");
      chk(sp_out == 8'hFC, "R4 sp", sp_out, 8'hFC);
      chk(ram[9'h0FF] == 4'hC, "R4 nib0", ram[9'h0FF], 4'hC);
      chk(ram[9'h0FE] == 4'h5, "R4 nib1", ram[9'h0FE], 4'h5);
      chk(ram[9'h0FD] == 4'hA, "R4 nib2", ram[9'h0FD], 4'hA);
      chk(ram[9'h0FC] == 4'h2, "R4 nib3", ram[9'h0FC], 4'h2);
      chk(ram[9'h0FB] == 4'h0, "R4 no extra write", ram[9'h0FB], 0);
      do_pop(4, "R6 compat pop");
      chk(pc_out == 14'h2A5C, "R6 pc", pc_out, 14'h2A5C);
      chk(stat_out == 8'h00, "R6 status kept", stat_out, 0);
      chk(sp_out == 8'h00, "R6 sp", sp_out, 0);
   endtask

   task automatic t_cfg;
      cfg_write(4'b0001);
      chk(cfg_rdata == 4'b0001, "R2 write", cfg_rdata, 1);
      chk(cfg_err == 1'b0, "R3 no err", cfg_err, 0);
      call_fast = 1'b0; ext_only_op = 1'b1; #1;
      chk(call_cycles == 4, "R7 long ext", call_cycles, 4);
      chk(illegal_op == 1'b0, "R8 ext op ext", illegal_op, 0);
      call_fast = 1'b1; #1;
      chk(call_cycles == 3, "R7 fast ext", call_cycles, 3);
      ext_only_op = 1'b0;
      foreach (bad_vals[i]) begin
         @(negedge clk); cfg_we = 1'b1; cfg_wdata = bad_vals[i];
         @(negedge clk); cfg_we = 1'b0;
         chk(cfg_err == 1'b1, "R3 err flag", cfg_err, 1);
         chk(cfg_rdata == 4'b0001, "R3 kept", cfg_rdata, 1);
         @(negedge clk);
         chk(cfg_err == 1'b0, "R3 err clears", cfg_err, 0);
      end
   endtask
   logic [3:0] bad_vals [3] = '{4'b0110, 4'b1010, 4'b0100};

   task automatic t_push_pop_ext;
      do_push(14'h1357, 8'hB4, 6, "R5 busy length");
      chk(sp_out == 8'hFA, "R5 sp", sp_out, 8'hFA);
      chk(ram[9'h1FF] == 4'h7, "R10 bank1 nib0", ram[9'h1FF], 7);
      chk(ram[9'h1FE] == 4'h5, "R5 nib1", ram[9'h1FE], 5);
      chk(ram[9'h1FD] == 4'h3, "R5 nib2", ram[9'h1FD], 3);
      chk(ram[9'h1FC] == 4'h1, "R5 nib3", ram[9'h1FC], 1);
      chk(ram[9'h1FB] == 4'h4, "R5 stat lo", ram[9'h1FB], 4);
      chk(ram[9'h1FA] == 4'hB, "R5 stat hi", ram[9'h1FA], 4'hB);
      chk(ram[9'h0FF] == 4'hC, "R10 bank0 untouched", ram[9'h0FF], 4'hC);
      do_pop(6, "R6 ext pop");
      chk(pc_out == 14'h1357, "R6 ext pc", pc_out, 14'h1357);
      chk(stat_out == 8'hB4, "R6 ext status", stat_out, 8'hB4);
      chk(sp_out == 8'h00, "R6 ext sp", sp_out, 0);
   endtask

   task automatic t_holdoff;
      int re_seen = 0;
      int n = 0;
      @(negedge clk); push_req = 1'b1; ret_pc = 14'h0F0F; stat_in = 8'h3C;
      @(negedge clk); push_req = 1'b0;
      @(negedge clk); pop_req = 1'b1;
      while (busy && n < 20) begin
         if (mem_re) re_seen++;
         n++;
         @(negedge clk);
      end
      chk(re_seen == 0, "R9 no read during push", re_seen, 0);
      chk(sp_out == 8'hFA, "R9 push completed", sp_out, 8'hFA);
      @(negedge clk); pop_req = 1'b0;
      while (busy) @(negedge clk);
      chk(pc_out == 14'h0F0F, "R9 held pop restores", pc_out, 14'h0F0F);
      chk(stat_out == 8'h3C, "R9 held pop status", stat_out, 8'h3C);
      chk(sp_out == 8'h00, "R9 sp back", sp_out, 0);
      @(negedge clk); push_req = 1'b1; pop_req = 1'b1; ret_pc = 14'h0123; stat_in = 8'h00;
      @(negedge clk); push_req = 1'b0; pop_req = 1'b0;
      chk(mem_we == 1'b1 && mem_re == 1'b0, "R9 push priority", {mem_we, mem_re}, 2);
      while (busy) @(negedge clk);
      chk(sp_out == 8'hFA, "R9 priority sp", sp_out, 8'hFA);
   endtask

   initial begin
      foreach (ram[i]) ram[i] = 4'h0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_timing_compat();
      t_push_pop_compat();
      t_cfg();
      t_push_pop_ext();
      t_holdoff();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         nchk++; nfail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end
endmodule